// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block decides, rank by rank, when DRAM devices may sit in their low-power idle mode. It watches how many requests the memory controller's queue holds for each rank, whether the rank is still busy with an earlier access, and whether a refresh is due for it. A rank with nothing queued, nothing in flight and no refresh due is put to sleep at once by dropping its clock enable. It is woken by the first request queued to it or by a due refresh.

Each rank has its own small state machine with four states: awake, entering sleep, asleep and waking. Once a rank drops its clock enable, it is held low for a minimum residency before a wake can begin. After the clock enable returns high, the rank is not reported ready to the scheduler until a fixed exit latency has passed. A shared counter records wakes caused by queued requests, which are the requests that found their rank asleep. A global disable input stops any rank from going to sleep and also wakes ranks that are asleep.

Top module: `rank_pd_ctrl`

## Requirements
- R1: After reset every bit of `cke` and `rankReady` is 1 and `powerUpCount` is 0.
- R2: A ready rank r whose pending count (`pendCnt[r*CNT_W +: CNT_W]`) is zero, with `rankBusy[r]` and `refreshDue[r]` low and `pdDisable` low, drives `cke[r]` and `rankReady[r]` low on the next clock edge.
- R3: A ready rank with a nonzero pending count, busy set or refresh due stays ready with `cke` high on the next edge.
- R4: Once `cke[r]` falls it stays low for at least ENTRY_HOLD+1 cycles, even if a request arrives during that time.
- R5: A sleeping rank (past its minimum residency) with a nonzero pending count raises `cke[r]` on the next edge.
- R6: A sleeping rank with `refreshDue[r]` high raises `cke[r]` on the next edge. With no request, no refresh and no disable it stays asleep.
- R7: `rankReady[r]` rises exactly EXIT_LAT cycles after `cke[r]` rises, and is never high while `cke[r]` is low.
- R8: While `pdDisable` is high no ready rank leaves the ready state. Sleeping ranks wake just as they do for a refresh, and these wakes are not counted.
- R9: `powerUpCount` rises by the number of ranks that wake in a cycle with a nonzero pending count. Wakes caused only by refresh or disable leave it unchanged.
- R10: Ranks act independently: several ranks may sleep and wake on the same edge, each by its own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pdDisable | input | 1 | Keeps every rank awake |
| pendCnt | input | NUM_RANKS*CNT_W | Queued request count per rank, rank r at bits r*CNT_W +: CNT_W |
| rankBusy | input | NUM_RANKS | Rank still serving an access |
| refreshDue | input | NUM_RANKS | Refresh needed for the rank |
| cke | output | NUM_RANKS | Clock enable per rank, low while asleep |
| rankReady | output | NUM_RANKS | Rank may accept commands |
| powerUpCount | output | EVT_W | Wakes caused by queued requests, wrapping |

## Verification
Checked on every cycle: the entry rule and the hold rule for ready ranks, the minimum low time of each clock enable, the exact exit latency, ready never being high while the clock enable is low, and the counter moving only in a cycle where some clock enable rises. Only the bench scenarios can show which trigger woke a rank, that refresh and disable wakes leave the counter alone, that a request arriving during the entry hold is served once the hold ends, and that several ranks can change state on the same edge.

// File: rtl/rank_pd_pkg.sv
package rank_pd_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_WAKE   = 2'd3
  } rank_state_e;

  // strobes from one rank's control to the shared datapath
  typedef struct packed {
    logic loadEntry;
    logic loadExit;
    logic wakeByReq;
  } rank_strobe_t;
endpackage

// File: rtl/rank_pd_fsm.sv
module rank_pd_fsm
  import rank_pd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pdDisable,
  input  logic         reqPending,
  input  logic         rankBusy,
  input  logic         refreshDue,
  input  logic         tmrDone,
  output rank_strobe_t strobe,
  output logic         cke,
  output logic         ready
);
  rank_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_AWAKE: begin
        if (!pdDisable && !reqPending && !rankBusy && !refreshDue) begin
          nextState        = ST_ENTER;
          strobe.loadEntry = 1'b1;
        end
      end
      ST_ENTER: begin
        if (tmrDone) nextState = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (reqPending || refreshDue || pdDisable) begin
          nextState        = ST_WAKE;
          strobe.loadExit  = 1'b1;
          strobe.wakeByReq = reqPending;
        end
      end
      ST_WAKE: begin
        if (tmrDone) nextState = ST_AWAKE;
      end
      default: nextState = ST_AWAKE;
    endcase
  end

  assign cke   = (state != ST_ENTER) && (state != ST_ASLEEP);
  assign ready = (state == ST_AWAKE);
endmodule

// File: rtl/rank_pd_datapath.sv
module rank_pd_datapath
  import rank_pd_pkg::*;
#(
  parameter int NUM_RANKS  = 8,
  parameter int CNT_W      = 4,
  parameter int ENTRY_HOLD = 4,
  parameter int EXIT_LAT   = 3,
  parameter int EVT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_RANKS*CNT_W-1:0]    pendCnt,
  input  rank_strobe_t [NUM_RANKS-1:0]  strobes,
  output logic [NUM_RANKS-1:0]          reqPending,
  output logic [NUM_RANKS-1:0]          tmrDone,
  output logic [EVT_W-1:0]              powerUpCount
);
  localparam int TMR_MAX = (ENTRY_HOLD > EXIT_LAT) ? ENTRY_HOLD : EXIT_LAT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int SUM_W   = $clog2(NUM_RANKS + 1);
  localparam logic [TMR_W-1:0] ENTRY_LOAD = TMR_W'(ENTRY_HOLD - 1);
  localparam logic [TMR_W-1:0] EXIT_LOAD  = TMR_W'(EXIT_LAT - 1);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [TMR_W-1:0] tmr;

    assign reqPending[r] = |pendCnt[r*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (!rstN)                     tmr <= '0;
      else if (strobes[r].loadEntry) tmr <= ENTRY_LOAD;
      else if (strobes[r].loadExit)  tmr <= EXIT_LOAD;
      else if (tmr != '0)            tmr <= tmr - 1'b1;
    end

    assign tmrDone[r] = (tmr == '0);
  end

  logic [SUM_W-1:0] wakeSum;
  always_comb begin
    wakeSum = '0;
    for (int r = 0; r < NUM_RANKS; r++) wakeSum = wakeSum + SUM_W'(strobes[r].wakeByReq);
  end

  always_ff @(posedge clk) begin
    if (!rstN) powerUpCount <= '0;
    else       powerUpCount <= powerUpCount + EVT_W'(wakeSum);
  end
endmodule

// File: rtl/rank_pd_ctrl.sv
module rank_pd_ctrl
  import rank_pd_pkg::*;
#(
  parameter int NUM_RANKS  = 8,
  parameter int CNT_W      = 4,
  parameter int ENTRY_HOLD = 4,
  parameter int EXIT_LAT   = 3,
  parameter int EVT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pdDisable,
  input  logic [NUM_RANKS*CNT_W-1:0] pendCnt,
  input  logic [NUM_RANKS-1:0]       rankBusy,
  input  logic [NUM_RANKS-1:0]       refreshDue,
  output logic [NUM_RANKS-1:0]       cke,
  output logic [NUM_RANKS-1:0]       rankReady,
  output logic [EVT_W-1:0]           powerUpCount
);
  rank_strobe_t [NUM_RANKS-1:0] strobes;
  logic [NUM_RANKS-1:0] reqPending;
  logic [NUM_RANKS-1:0] tmrDone;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_fsm
    rank_pd_fsm u_fsm (
      .clk        (clk),
      .rstN       (rstN),
      .pdDisable  (pdDisable),
      .reqPending (reqPending[r]),
      .rankBusy   (rankBusy[r]),
      .refreshDue (refreshDue[r]),
      .tmrDone    (tmrDone[r]),
      .strobe     (strobes[r]),
      .cke        (cke[r]),
      .ready      (rankReady[r])
    );
  end

  rank_pd_datapath #(
    .NUM_RANKS  (NUM_RANKS),
    .CNT_W      (CNT_W),
    .ENTRY_HOLD (ENTRY_HOLD),
    .EXIT_LAT   (EXIT_LAT),
    .EVT_W      (EVT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pendCnt      (pendCnt),
    .strobes      (strobes),
    .reqPending   (reqPending),
    .tmrDone      (tmrDone),
    .powerUpCount (powerUpCount)
  );
endmodule

// File: rtl/rank_pd_chk.sv
module rank_pd_chk #(
  parameter int NUM_RANKS  = 8,
  parameter int CNT_W      = 4,
  parameter int ENTRY_HOLD = 4,
  parameter int EXIT_LAT   = 3,
  parameter int EVT_W      = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pdDisable,
  input logic [NUM_RANKS*CNT_W-1:0] pendCnt,
  input logic [NUM_RANKS-1:0]       rankBusy,
  input logic [NUM_RANKS-1:0]       refreshDue,
  input logic [NUM_RANKS-1:0]       cke,
  input logic [NUM_RANKS-1:0]       rankReady,
  input logic [EVT_W-1:0]           powerUpCount
);
  localparam int CAP   = ENTRY_HOLD + EXIT_LAT + 4;
  localparam int CNT_B = $clog2(CAP + 1);
  localparam logic [CNT_B-1:0] CAP_V = CNT_B'(CAP);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    logic [CNT_B-1:0] lowCnt, wakeCnt;
    logic idleIn;
    assign idleIn = !pdDisable && !rankBusy[r] && !refreshDue[r] &&
                    (pendCnt[r*CNT_W +: CNT_W] == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lowCnt  <= '0;
        wakeCnt <= '0;
      end else begin
        lowCnt  <= cke[r] ? '0 : ((lowCnt < CAP_V) ? lowCnt + 1'b1 : lowCnt);
        wakeCnt <= (!cke[r] || rankReady[r]) ? '0 :
                   ((wakeCnt < CAP_V) ? wakeCnt + 1'b1 : wakeCnt);
      end
    end

    // R2
    entry_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      rankReady[r] && idleIn |=> !cke[r] && !rankReady[r]);

    // R3
    hold_when_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
      rankReady[r] && !pdDisable && !idleIn |=> rankReady[r] && cke[r]);

    // R8
    disable_keeps_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
      rankReady[r] && pdDisable |=> rankReady[r] && cke[r]);

    // R4
    min_residency_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cke[r]) |-> lowCnt >= CNT_B'(ENTRY_HOLD + 1));

    // R7
    exit_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rankReady[r]) |-> wakeCnt == CNT_B'(EXIT_LAT));

    // R7
    ready_needs_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
      rankReady[r] |-> cke[r]);
  end

  // R9
  count_only_on_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerUpCount != $past(powerUpCount) |-> (cke & ~$past(cke)) != '0);
endmodule

bind rank_pd_ctrl rank_pd_chk #(
  .NUM_RANKS  (NUM_RANKS),
  .CNT_W      (CNT_W),
  .ENTRY_HOLD (ENTRY_HOLD),
  .EXIT_LAT   (EXIT_LAT),
  .EVT_W      (EVT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pdDisable    (pdDisable),
  .pendCnt      (pendCnt),
  .rankBusy     (rankBusy),
  .refreshDue   (refreshDue),
  .cke          (cke),
  .rankReady    (rankReady),
  .powerUpCount (powerUpCount)
);

// File: tb/rank_pd_ctrl_bench.sv
module rank_pd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdDisable = 1'b1;
  logic [NR*CW-1:0] pendCnt = '0;
  logic [NR-1:0] rankBusy = '0;
  logic [NR-1:0] refreshDue = '0;
  logic [NR-1:0] cke, rankReady;
  logic [15:0] powerUpCount;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int          atCycle;
    string       tag;
    logic [7:0]  expCke;
    logic [7:0]  expRdy;
    logic [15:0] expCnt;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rank_pd_ctrl u_rank_pd_ctrl (
    .clk(clk), .rstN(rstN), .pdDisable(pdDisable), .pendCnt(pendCnt),
    .rankBusy(rankBusy), .refreshDue(refreshDue), .cke(cke),
    .rankReady(rankReady), .powerUpCount(powerUpCount)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver side: queue an expectation d cycles ahead
  task automatic expect_at(input string tag, input int d, input logic [7:0] c,
                           input logic [7:0] r, input logic [15:0] n);
    exp_t it;
    int idx;
    it.atCycle = cyc + d; it.tag = tag; it.expCke = c; it.expRdy = r; it.expCnt = n;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].atCycle > it.atCycle) begin idx = i; break; end
    end
    sb.insert(idx, it);
  endtask

  task automatic setPend(input int r, input logic [CW-1:0] v);
    pendCnt[r*CW +: CW] = v;
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].atCycle <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (cke !== it.expCke || rankReady !== it.expRdy || powerUpCount !== it.expCnt) begin
        fails++;
        $display("FAIL %s cyc=%0d: cke=%h rdy=%h cnt=%0d expected cke=%h rdy=%h cnt=%0d",
                 it.tag, cyc, cke, rankReady, powerUpCount, it.expCke, it.expRdy, it.expCnt);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 3000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    expect_at("R1 reset state", 0, 8'hFF, 8'hFF, 16'd0);
    // R8: disable held with every rank idle
    for (int d = 2; d <= 6; d += 2) expect_at("R8 disable holds awake", d, 8'hFF, 8'hFF, 16'd0);
    step(7);

    // R2 rank0 idle; R3 others kept awake by pending, refresh, busy
    pdDisable = 1'b0;
    rankBusy  = 8'hF8;
    setPend(1, 4'd2);
    refreshDue[2] = 1'b1;
    expect_at("R2 R3 entry of idle rank only", 1, 8'hFE, 8'hFE, 16'd0);
    expect_at("R3 needed ranks stay ready", 3, 8'hFE, 8'hFE, 16'd0);
    step(1);
    // request during entry hold
    setPend(0, 4'd1);
    expect_at("R4 still low through hold", 4, 8'hFE, 8'hFE, 16'd0);
    expect_at("R5 R9 request wake counted", 5, 8'hFF, 8'hFE, 16'd1);
    expect_at("R7 not ready before latency", 7, 8'hFF, 8'hFE, 16'd1);
    expect_at("R7 ready after latency", 8, 8'hFF, 8'hFF, 16'd1);
    step(9);

    // refresh wake, not counted
    setPend(0, 4'd0);
    expect_at("R2 re-entry", 1, 8'hFE, 8'hFE, 16'd1);
    expect_at("R6 stays asleep without trigger", 8, 8'hFE, 8'hFE, 16'd1);
    step(8);
    refreshDue[0] = 1'b1;
    expect_at("R6 R9 refresh wake not counted", 1, 8'hFF, 8'hFE, 16'd1);
    expect_at("R7 refresh wake latency", 3, 8'hFF, 8'hFE, 16'd1);
    expect_at("R7 refresh wake ready", 4, 8'hFF, 8'hFF, 16'd1);
    step(4);

    // all ranks sleep together
    refreshDue = '0;
    rankBusy   = '0;
    pendCnt    = '0;
    expect_at("R10 all ranks enter together", 1, 8'h00, 8'h00, 16'd1);
    step(10);
    setPend(2, 4'd3);
    setPend(5, 4'd1);
    refreshDue[6] = 1'b1;
    expect_at("R9 R10 mixed wake counts two", 1, 8'h64, 8'h00, 16'd3);
    expect_at("R10 mixed wake ready", 4, 8'h64, 8'h64, 16'd3);
    step(5);

    // disable wakes the rest, not counted
    pdDisable = 1'b1;
    expect_at("R8 disable wakes sleepers", 1, 8'hFF, 8'h64, 16'd3);
    expect_at("R8 disable wake ready", 4, 8'hFF, 8'hFF, 16'd3);
    step(8);

    while (sb.size() > 0) step(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule